// File: doc/BRIEF.md
# Edge-Pulse Channel Encoder with Refresh

This block is the sending half of one isolated digital channel. It watches a single logic input, passes it through a flip-flop synchronizer, and reports each change of level as a one-clock pulse. A rising input produces a pulse on the set output. A falling input produces a pulse on the clear output. A receiver that holds a bistable latch can rebuild the input level from these two pulse streams.

Transition pulses alone would leave the far side wrong after a lost or corrupted pulse. For that reason the block also sends refresh pulses while the input is quiet. Once IDLE_CYCLES clocks have passed without a transition, it sends a pulse of the type that matches the present level. After that it repeats one every REFRESH_CYCLES clocks until the next transition, which restarts the idle wait.

A disable input mutes the channel completely. While it is high, no transition pulse and no refresh pulse is sent. When it is released, the present level goes out at once as a refresh pulse, even if the input never moved.

Top module: `edge_pulse_enc`

## Requirements
- R1: While reset is low, both pulse outputs are 0. After reset is released, no pulse appears until the synchronizer holds a captured level. With a steady input and disable low, the first pulse is a refresh that is visible IDLE_CYCLES+3 clock edges after the release.
- R2: A 0-to-1 change on din_i gives a set pulse (set_pulse_o=1, clr_pulse_o=0) on the third rising clock edge after the change: two synchronizer stages plus one output register.
- R3: A 1-to-0 change on din_i gives a clear pulse (clr_pulse_o=1, set_pulse_o=0) with the same three-edge latency.
- R4: Every pulse lasts exactly one clock cycle. Two transitions that reach the synchronizer output on consecutive cycles each give their own pulse, on consecutive cycles.
- R5: When no transition has occurred for IDLE_CYCLES cycles, a refresh pulse is sent. Its type is set for a high level and clear for a low level. Further refresh pulses of the same kind follow every REFRESH_CYCLES cycles while the input stays steady.
- R6: A transition restarts the idle wait. The next refresh follows the transition pulse by IDLE_CYCLES cycles, and no refresh due under the old schedule is sent.
- R7: set_pulse_o and clr_pulse_o are never 1 in the same cycle.
- R8: When a transition is detected in the same cycle as a due refresh, only the transition pulse is sent, and the idle wait restarts from that transition.
- R9: While dis_i is 1, no pulse of either type is sent. This includes input transitions that occur during the disabled period; they are never sent as transition pulses.
- R10: On the first clock edge after dis_i returns to 0, a refresh pulse of the present level is sent. Refresh pulses then follow every REFRESH_CYCLES cycles while the input stays steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Logic input to be encoded; may be asynchronous |
| dis_i | input | 1 | Disable; 1 mutes all pulses, synchronous to clk_i |
| set_pulse_o | output | 1 | One-cycle pulse marking a high level (rising edge or refresh) |
| clr_pulse_o | output | 1 | One-cycle pulse marking a low level (falling edge or refresh) |

## Verification
The level assertions assume that din_i is captured cleanly by the first synchronizer stage, so that the value sampled SYNC_STAGES+1 edges earlier is the level a pulse encodes. The disable assertions assume that dis_i is already synchronous to clk_i. The bench meets both assumptions by changing din_i and dis_i only on falling clock edges, far from the capturing rising edge. It also holds each din_i level for at least one full cycle, so that no level is shorter than a synchronizer stage can resolve.

// File: rtl/epe_pkg.sv
package epe_pkg;

    // Phase of the shared quiet-time counter
    typedef enum logic {
        PH_IDLE    = 1'b0,   // waiting for the first refresh after activity
        PH_REFRESH = 1'b1    // steady input, periodic refresh running
    } epe_phase_e;

endpackage

// File: rtl/epe_sync.sv
module epe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o,
    output logic valid_o
);

    localparam int FW = $clog2(STAGES + 1);
    localparam logic [FW-1:0] FILL_FULL = FW'(STAGES);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic [FW-1:0]     fill;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        // count edges until the last stage carries a sampled value
        if (st_q.fill != FILL_FULL) begin
            st_d.fill = st_q.fill + FW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o     = st_q.chain[STAGES-1];
    assign valid_o = (st_q.fill == FILL_FULL);

endmodule

// File: rtl/epe_timer.sv
module epe_timer
    import epe_pkg::*;
#(
    parameter int IDLE_CYCLES    = 256,
    parameter int REFRESH_CYCLES = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic armed_i,    // a captured level exists
    input  logic hold_i,     // channel muted: park so release fires at once
    input  logic restart_i,  // a transition was seen this cycle
    output logic due_o       // a refresh falls due this cycle
);

    localparam int MAXC = (IDLE_CYCLES > REFRESH_CYCLES) ? IDLE_CYCLES : REFRESH_CYCLES;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES - 1);
    localparam logic [CW-1:0] REF_LAST  = CW'(REFRESH_CYCLES - 1);

    typedef struct packed {
        epe_phase_e    ph;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    due;

    always_comb begin
        if (st_q.ph == PH_IDLE) begin
            due = (st_q.cnt == IDLE_LAST);
        end else begin
            due = (st_q.cnt == REF_LAST);
        end

        st_d = st_q;
        if (!armed_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else if (hold_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = IDLE_LAST;
        end else if (restart_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else if (due) begin
            st_d.ph  = PH_REFRESH;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign due_o = due;

endmodule

// File: rtl/epe_pulse_gen.sv
module epe_pulse_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,    // synchronized input level
    input  logic valid_i,    // level_i carries a sampled value
    input  logic dis_i,
    input  logic due_i,
    output logic armed_o,
    output logic restart_o,
    output logic set_o,
    output logic clr_o
);

    typedef struct packed {
        logic lvl;
        logic armed;
        logic set;
        logic clr;
    } pg_st_t;

    pg_st_t st_d, st_q;
    logic   edge_seen;
    logic   fire;

    always_comb begin
        edge_seen = st_q.armed && (level_i != st_q.lvl);
        // a transition and a due refresh both encode level_i, so one pulse covers both
        fire      = !dis_i && (edge_seen || due_i);

        st_d     = st_q;
        st_d.set = 1'b0;
        st_d.clr = 1'b0;
        if (valid_i) begin
            st_d.lvl   = level_i;
            st_d.armed = 1'b1;
            if (st_q.armed && fire) begin
                st_d.set = level_i;
                st_d.clr = !level_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o   = st_q.armed;
    assign restart_o = edge_seen;
    assign set_o     = st_q.set;
    assign clr_o     = st_q.clr;

endmodule

// File: rtl/edge_pulse_enc.sv
module edge_pulse_enc #(
    parameter int SYNC_STAGES    = 2,
    parameter int IDLE_CYCLES    = 256,
    parameter int REFRESH_CYCLES = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    input  logic dis_i,
    output logic set_pulse_o,
    output logic clr_pulse_o
);

    logic lvl_sync;
    logic lvl_valid;
    logic armed;
    logic restart;
    logic due;

    epe_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (din_i),
        .q_o    (lvl_sync),
        .valid_o(lvl_valid)
    );

    epe_timer #(
        .IDLE_CYCLES   (IDLE_CYCLES),
        .REFRESH_CYCLES(REFRESH_CYCLES)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .armed_i  (armed),
        .hold_i   (dis_i),
        .restart_i(restart),
        .due_o    (due)
    );

    epe_pulse_gen u_pgen (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (lvl_sync),
        .valid_i  (lvl_valid),
        .dis_i    (dis_i),
        .due_i    (due),
        .armed_o  (armed),
        .restart_o(restart),
        .set_o    (set_pulse_o),
        .clr_o    (clr_pulse_o)
    );

endmodule

// File: rtl/edge_pulse_enc_chk.sv
module edge_pulse_enc_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic din_i,
    input logic dis_i,
    input logic set_pulse_o,
    input logic clr_pulse_o
);

    localparam int AW = $clog2(SYNC_STAGES + 4) + 1;
    localparam logic [AW-1:0] AGE_MAX = {AW{1'b1}};
    localparam logic [AW-1:0] QUIET   = AW'(SYNC_STAGES);
    localparam logic [AW-1:0] SETTLED = AW'(SYNC_STAGES + 2);

    logic [AW-1:0]        age_q;
    logic [SYNC_STAGES:0] hist_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q  <= '0;
            hist_q <= '0;
        end else begin
            if (age_q != AGE_MAX) begin
                age_q <= age_q + AW'(1);
            end
            hist_q <= {hist_q[SYNC_STAGES-1:0], din_i};
        end
    end

    // R1: no pulse before the synchronizer holds a level
    p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q <= QUIET) |-> (!set_pulse_o && !clr_pulse_o));

    // R2: a set pulse encodes a high input level
    p_set_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_pulse_o |-> hist_q[SYNC_STAGES]);

    // R3: a clear pulse encodes a low input level
    p_clr_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_pulse_o |-> !hist_q[SYNC_STAGES]);

    // R4: set pulses last one cycle
    p_set_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_pulse_o |=> !set_pulse_o);

    // R4: clear pulses last one cycle
    p_clr_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_pulse_o |=> !clr_pulse_o);

    // R7: the two outputs never fire together
    p_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(set_pulse_o && clr_pulse_o));

    // R9: a disabled cycle produces no pulse
    p_muted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dis_i |=> (!set_pulse_o && !clr_pulse_o));

    // R10: release of disable re-sends the level on the next edge
    p_release_refresh_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q >= SETTLED) && $fell(dis_i)) |=> (set_pulse_o || clr_pulse_o));

endmodule

bind edge_pulse_enc edge_pulse_enc_chk #(
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .din_i      (din_i),
    .dis_i      (dis_i),
    .set_pulse_o(set_pulse_o),
    .clr_pulse_o(clr_pulse_o)
);

// File: tb/edge_pulse_enc_tb.sv
module edge_pulse_enc_tb;

    localparam int IDLE_N = 16;
    localparam int REF_N  = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic din   = 1'b0;
    logic dis   = 1'b0;
    logic set_p;
    logic clr_p;

    int checks   = 0;
    int errors   = 0;
    int overlaps = 0;
    int n        = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    edge_pulse_enc #(
        .SYNC_STAGES   (2),
        .IDLE_CYCLES   (IDLE_N),
        .REFRESH_CYCLES(REF_N)
    ) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .din_i      (din),
        .dis_i      (dis),
        .set_pulse_o(set_p),
        .clr_pulse_o(clr_p)
    );

    // One scenario: reset with init level, then at sample 4 drive new level and
    // disable, then count pulses over samples 5 .. 4+cyc
    typedef struct packed {
        logic       init;
        logic       dis;
        logic       nd;
        logic [7:0] cyc;
        logic [7:0] exp_set;
        logic [7:0] exp_clr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b1, 8'd40, 8'd4, 8'd0},  // R2 R5: rise, then refreshes
        '{1'b1, 1'b0, 1'b0, 8'd40, 8'd0, 8'd4},  // R3 R5: fall, then refreshes
        '{1'b0, 1'b0, 1'b0, 8'd40, 8'd0, 8'd4},  // R5: steady low
        '{1'b1, 1'b0, 1'b1, 8'd40, 8'd4, 8'd0},  // R5: steady high
        '{1'b0, 1'b1, 1'b1, 8'd40, 8'd0, 8'd0},  // R9: rise while muted
        '{1'b1, 1'b1, 1'b0, 8'd40, 8'd0, 8'd0},  // R9: fall while muted
        '{1'b0, 1'b0, 1'b1, 8'd20, 8'd2, 8'd0},  // R6: short window after rise
        '{1'b0, 1'b0, 1'b0, 8'd20, 8'd0, 8'd1}   // R5: short window steady
    };

    task automatic chk_now(input string tag, input logic es, input logic ec);
        checks++;
        if (set_p !== es || clr_p !== ec) begin
            errors++;
            $display("FAIL %s at sample %0d: set/clr got %b%b expected %b%b",
                     tag, n, set_p, clr_p, es, ec);
        end
    endtask

    task automatic chk_cnt(input string tag, input int gs, input int gc,
                           input int es, input int ec);
        checks++;
        if (gs != es || gc != ec) begin
            errors++;
            $display("FAIL %s: set/clr counts got %0d/%0d expected %0d/%0d",
                     tag, gs, gc, es, ec);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        n++;
        if (set_p === 1'b1 && clr_p === 1'b1) overlaps++;
    endtask

    task automatic go_to(input int k);
        while (n < k) adv();
    endtask

    task automatic count_to(input int k, inout int cs, inout int cc);
        while (n < k) begin
            adv();
            if (set_p === 1'b1) cs++;
            if (clr_p === 1'b1) cc++;
        end
    endtask

    task automatic restart(input logic lvl, input logic d);
        @(negedge clk);
        rst_n = 1'b0;
        din   = lvl;
        dis   = d;
        repeat (2) @(negedge clk);
        chk_now("R1 reset outputs", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        n     = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int cs;
        int cc;

        // Vector table
        for (int i = 0; i < 8; i++) begin
            restart(VECS[i].init, 1'b0);
            go_to(4);
            din = VECS[i].nd;
            dis = VECS[i].dis;
            cs = 0;
            cc = 0;
            count_to(4 + int'(VECS[i].cyc), cs, cc);
            chk_cnt($sformatf("vector %0d (R2 R3 R5 R6 R9)", i), cs, cc,
                    int'(VECS[i].exp_set), int'(VECS[i].exp_clr));
        end

        // R1 R5: silent until the first refresh, then fixed period
        restart(1'b0, 1'b0);
        cs = 0; cc = 0;
        count_to(18, cs, cc);
        chk_cnt("R1 silent after reset", cs, cc, 0, 0);
        go_to(19);
        chk_now("R5 first refresh", 1'b0, 1'b1);
        cs = 0; cc = 0;
        count_to(26, cs, cc);
        chk_cnt("R5 gap between refreshes", cs, cc, 0, 0);
        go_to(27);
        chk_now("R5 refresh period", 1'b0, 1'b1);

        // R2 R3 R4 R6: back-to-back edges, then restarted idle wait
        restart(1'b0, 1'b0);
        go_to(10);
        din = 1'b1;
        go_to(11);
        din = 1'b0;
        go_to(12);
        chk_now("R2 no early pulse", 1'b0, 1'b0);
        go_to(13);
        chk_now("R2 rise latency", 1'b1, 1'b0);
        go_to(14);
        chk_now("R3 fall latency R4 adjacent", 1'b0, 1'b1);
        go_to(15);
        chk_now("R4 one cycle wide", 1'b0, 1'b0);
        cs = 0; cc = 0;
        count_to(29, cs, cc);
        chk_cnt("R6 old refresh dropped", cs, cc, 0, 0);
        go_to(30);
        chk_now("R6 refresh after restart", 1'b0, 1'b1);

        // R8: edge lands on a due refresh
        restart(1'b0, 1'b0);
        go_to(32);
        din = 1'b1;
        go_to(35);
        chk_now("R8 transition wins", 1'b1, 1'b0);
        cs = 0; cc = 0;
        count_to(50, cs, cc);
        chk_cnt("R8 no refresh before restart ends", cs, cc, 0, 0);
        go_to(51);
        chk_now("R8 refresh after idle restart", 1'b1, 1'b0);

        // R9 R10: mute, hidden transition, release
        restart(1'b0, 1'b0);
        go_to(4);
        dis = 1'b1;
        cs = 0; cc = 0;
        count_to(10, cs, cc);
        din = 1'b1;
        count_to(30, cs, cc);
        chk_cnt("R9 muted channel", cs, cc, 0, 0);
        dis = 1'b0;
        go_to(31);
        chk_now("R10 refresh on release", 1'b1, 1'b0);
        cs = 0; cc = 0;
        count_to(38, cs, cc);
        chk_cnt("R10 gap after release", cs, cc, 0, 0);
        go_to(39);
        chk_now("R10 periodic after release", 1'b1, 1'b0);

        // R7: never both outputs high over the whole run
        chk_cnt("R7 exclusive outputs", overlaps, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule